// File: doc/BRIEF.md
# Polyphase FIR Interpolator

This block raises the sample rate of a signed stream by an integer factor `PHASES` and removes the spectral images in the same pass. It never builds a zero-stuffed stream. Each accepted input sample is pushed into a short history buffer. The block then evaluates one sub-filter per output slot on a single shared multiply-accumulate unit. Sub-filter `k` uses the taps `h(PHASES*n + k)`. The finished results leave in phase order 0, 1, up to `PHASES-1`. The arithmetic therefore runs at the input rate, which is about `PHASES` times less work than filtering the expanded stream.

Control is a three-state machine. `ST_IDLE` waits for an input sample. Its transition *accept* (`in_valid` high in `ST_IDLE`) shifts the sample in and enters `ST_MAC`. `ST_MAC` walks the tap counter over `ceil(TAPS/PHASES)` cycles. Its transition *done* (the last tap) enters `ST_EMIT`. `ST_EMIT` presents the rounded, saturated result and waits for `out_ready`. Its transition *next_phase* goes back to `ST_MAC` with the phase counter incremented. Its transition *last_phase* (phase `PHASES-1` taken) returns to `ST_IDLE`. The coefficients come from a formula held in the package, so no table is stored by hand.

Top module: `polyphase_interp`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0.
- R2: Every accepted input sample produces exactly `PHASES` output transfers, in phase order 0 to `PHASES-1`, before the next input is accepted.
- R3: The phase-k output for input index m equals the sum over n of `h(PHASES*n+k)·x(m-n)`, where `h(i) = COEF_STEP·min(i+1, TAPS-i)` for `i < TAPS` and 0 otherwise. The defaults are PHASES=3, TAPS=12, COEF_STEP=2048.
- R4: The sum is scaled by adding `2^(SHIFT-1)` and then shifting arithmetically right by `SHIFT`, which is 14 by default. An exact half therefore rounds toward plus infinity.
- R5: A scaled value outside the signed `OUT_W`-bit range is clamped to the largest or the smallest representable value.
- R6: `in_ready` stays 0 from the acceptance of a sample until the output transfer of its last phase.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change.
- R8: Reset clears the sample history to zero, including a reset in the middle of a stream. The first outputs afterwards depend only on samples accepted since that reset.
- R9: Each phase takes `ceil(TAPS/PHASES)` multiply-accumulate cycles. `out_valid` stays 0 for exactly that many cycles after an input acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input sample |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Downstream takes the output sample |
| out_data | output | OUT_W | Signed interpolated output sample |

## Verification
The bound checker watches the handshakes on every cycle. It checks that a held output keeps its value, that exactly `PHASES` outputs follow each acceptance, and that no input is taken while phases are still pending. The numeric content cannot be shown by these properties. The bench scenarios show it: the tap-weighted sums, rounding at an exact half in both signs, clamping at both rails, history clearing by a mid-stream reset, and the multiply-accumulate latency. These scenarios are checked against a bench model of the filter.

// File: rtl/interp_pkg.sv
package interp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MAC,
        ST_EMIT
    } interp_state_t;

    // Triangular prototype kernel; zero beyond the last tap.
    function automatic int coef_value(input int idx, input int taps, input int step);
        int w;
        if (idx >= taps) return 0;
        w = (idx + 1 < taps - idx) ? idx + 1 : taps - idx;
        return step * w;
    endfunction

endpackage

// File: rtl/interp_history.sv
module interp_history #(
    parameter int IN_W  = 16,
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic signed [IN_W-1:0]  din,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic signed [IN_W-1:0]  rd_data
);

    logic signed [IN_W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[g] <= '0;
            end else if (shift_en) begin
                if (g == 0) stage[g] <= din;
                else        stage[g] <= stage[(g > 0) ? g - 1 : 0];
            end
        end
    end

    assign rd_data = stage[rd_idx];

endmodule

// File: rtl/interp_coef_rom.sv
module interp_coef_rom
    import interp_pkg::*;
#(
    parameter int PHASES    = 3,
    parameter int TAPS      = 12,
    parameter int COEF_W    = 16,
    parameter int COEF_STEP = 2048,
    parameter int TPP       = 4,
    parameter int PH_W      = 2,
    parameter int TAP_W     = 2
) (
    input  logic [PH_W-1:0]          phase,
    input  logic [TAP_W-1:0]         tap,
    output logic signed [COEF_W-1:0] coef
);

    logic signed [COEF_W-1:0] bank [PHASES][TPP];

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        for (genvar t = 0; t < TPP; t++) begin : g_tap
            assign bank[p][t] = COEF_W'(coef_value(t * PHASES + p, TAPS, COEF_STEP));
        end
    end

    assign coef = bank[phase][tap];

endmodule

// File: rtl/interp_mac.sv
module interp_mac #(
    parameter int IN_W   = 16,
    parameter int COEF_W = 16,
    parameter int OUT_W  = 16,
    parameter int ACC_W  = 35,
    parameter int SHIFT  = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     clr,
    input  logic signed [IN_W-1:0]   sample,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [OUT_W-1:0]  result
);

    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(64'sd1 <<< (SHIFT - 1));
    localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
    localparam logic signed [ACC_W-1:0] MINV = ACC_W'(-(64'sd1 <<< (OUT_W - 1)));

    logic signed [IN_W+COEF_W-1:0] prod;
    logic signed [ACC_W-1:0]       acc_q;
    logic signed [ACC_W-1:0]       base;
    logic signed [ACC_W-1:0]       scaled;

    assign prod = sample * coef;
    assign base = clr ? '0 : acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= base + ACC_W'(prod);
    end

    always_comb begin
        scaled = (acc_q + HALF) >>> SHIFT;
        if (scaled > MAXV)      result = OUT_W'(MAXV);
        else if (scaled < MINV) result = OUT_W'(MINV);
        else                    result = OUT_W'(scaled);
    end

endmodule

// File: rtl/polyphase_interp.sv
module polyphase_interp
    import interp_pkg::*;
#(
    parameter int PHASES    = 3,
    parameter int TAPS      = 12,
    parameter int IN_W      = 16,
    parameter int COEF_W    = 16,
    parameter int OUT_W     = 16,
    parameter int COEF_STEP = 2048,
    parameter int SHIFT     = 14
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic signed [IN_W-1:0]  in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic signed [OUT_W-1:0] out_data
);

    localparam int TPP   = (TAPS + PHASES - 1) / PHASES;
    localparam int TAP_W = (TPP > 1) ? $clog2(TPP) : 1;
    localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1;
    localparam int ACC_W = IN_W + COEF_W + TAP_W + 1;

    interp_state_t state_q, state_d;
    logic [PH_W-1:0]          phase_q;
    logic [TAP_W-1:0]         tap_q;
    logic                     tap_last, phase_last;
    logic                     shift_en, mac_en, mac_clr;
    logic signed [IN_W-1:0]   hist_data;
    logic signed [COEF_W-1:0] coef;

    assign tap_last   = (tap_q == TAP_W'(TPP - 1));
    assign phase_last = (phase_q == PH_W'(PHASES - 1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_MAC;
            ST_MAC:  if (tap_last)  state_d = ST_EMIT;
            ST_EMIT: if (out_ready) state_d = phase_last ? ST_IDLE : ST_MAC;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs and datapath strobes
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        mac_en    = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready  = 1'b1;
            ST_MAC:  mac_en    = 1'b1;
            ST_EMIT: out_valid = 1'b1;
            default: ;
        endcase
        shift_en = in_valid && in_ready;
        mac_clr  = (tap_q == '0);
    end

    // Phase and tap counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            tap_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    phase_q <= '0;
                    tap_q   <= '0;
                end
                ST_MAC:  tap_q <= tap_last ? '0 : tap_q + 1'b1;
                ST_EMIT: if (out_ready) phase_q <= phase_last ? '0 : phase_q + 1'b1;
                default: ;
            endcase
        end
    end

    interp_history #(
        .IN_W (IN_W),
        .DEPTH(TPP),
        .IDX_W(TAP_W)
    ) i_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (in_data),
        .rd_idx  (tap_q),
        .rd_data (hist_data)
    );

    interp_coef_rom #(
        .PHASES   (PHASES),
        .TAPS     (TAPS),
        .COEF_W   (COEF_W),
        .COEF_STEP(COEF_STEP),
        .TPP      (TPP),
        .PH_W     (PH_W),
        .TAP_W    (TAP_W)
    ) i_rom (
        .phase(phase_q),
        .tap  (tap_q),
        .coef (coef)
    );

    interp_mac #(
        .IN_W  (IN_W),
        .COEF_W(COEF_W),
        .OUT_W (OUT_W),
        .ACC_W (ACC_W),
        .SHIFT (SHIFT)
    ) i_mac (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mac_en),
        .clr   (mac_clr),
        .sample(hist_data),
        .coef  (coef),
        .result(out_data)
    );

endmodule

// File: rtl/interp_checker.sv
module interp_checker #(
    parameter int PHASES = 3,
    parameter int OUT_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_data
);

    logic       in_fire, out_fire;
    logic [7:0] pending;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pending <= '0;
        else if (in_fire)  pending <= 8'(PHASES);
        else if (out_fire) pending <= pending - 8'd1;
    end

    // R2: a new input only once all phases of the last one have left
    assert_phase_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> pending == 8'd0);

    // R2: no output transfer without a pending phase
    assert_no_extra_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_fire |-> pending != 8'd0);

    // R6: input side blocked while phases remain
    assert_ready_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pending != 8'd0 |-> !in_ready);

    // R7: a stalled output holds
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

bind polyphase_interp interp_checker #(
    .PHASES(PHASES),
    .OUT_W (OUT_W)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
);

// File: tb/test_polyphase_interp.sv
module test_polyphase_interp;

    localparam int PHASES = 3;
    localparam int TAPS   = 12;
    localparam int STEP   = 2048;
    localparam int SHIFT  = 14;
    localparam int TPP    = (TAPS + PHASES - 1) / PHASES;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic               in_ready;
    logic signed [15:0] in_data = '0;
    logic               out_valid;
    logic               out_ready = 1'b0;
    logic signed [15:0] out_data;

    int errors = 0;
    int checks = 0;
    longint hist [TPP];

    always #10 clk = ~clk;

    polyphase_interp i_polyphase_interp (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_data  (in_data),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data)
    );

    function automatic longint tap_weight(input int i);
        if (i >= TAPS) return 0;
        return longint'(STEP) * ((i + 1 < TAPS - i) ? i + 1 : TAPS - i);
    endfunction

    function automatic longint model_out(input int k);
        longint acc = 0;
        longint s;
        for (int n = 0; n < TPP; n++) acc += tap_weight(n * PHASES + k) * hist[n];
        s = (acc + (longint'(1) <<< (SHIFT - 1))) >>> SHIFT;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int n = 0; n < TPP; n++) hist[n] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        clear_model();
        @(negedge clk);
        check("R1 in_ready after reset", in_ready, 1);
        check("R1 out_valid after reset", out_valid, 0);
    endtask

    // Push one sample and drain its phases; req names the value check
    task automatic push(input logic signed [15:0] x, input int stall, input string req);
        int wait_cycles;
        logic signed [15:0] held;
        for (int n = TPP - 1; n > 0; n--) hist[n] = hist[n - 1];
        hist[0] = longint'(x);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = x;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        wait_cycles = 0;
        while (!out_valid) begin
            check("R6 in_ready low while computing", in_ready, 0);
            wait_cycles++;
            @(negedge clk);
        end
        check("R9 MAC latency", wait_cycles, TPP);
        for (int k = 0; k < PHASES; k++) begin
            while (!out_valid) @(negedge clk);
            held = out_data;
            for (int s = 0; s < stall; s++) begin
                @(negedge clk);
                check("R7 valid held", out_valid, 1);
                check("R7 data held", out_data, held);
            end
            check("R6 in_ready low during emit", in_ready, 0);
            check(req, out_data, model_out(k));
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            out_ready = 1'b0;
        end
        check("R2 back to accepting after last phase", in_ready, 1);
        check("R2 no extra output", out_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        clear_model();
        do_reset();

        // R8/R3: impulse after reset sees only itself
        push(16'sd4, 0, "R8 first outputs from fresh history");
        push(16'sd0, 1, "R3 impulse tail");
        push(16'sd0, 0, "R3 impulse tail");
        push(16'sd0, 2, "R3 impulse tail");

        // R4: exact halves in both signs
        do_reset();
        push(16'sd4, 0, "R4 round half up positive");
        do_reset();
        push(-16'sd4, 1, "R4 round half up negative");
        push(16'sd3, 0, "R4 rounding mixed");

        // R5: clamp at both rails
        for (int i = 0; i < 4; i++) push(16'sd32767, i, "R5 positive clamp");
        for (int i = 0; i < 4; i++) push(-16'sd32768, 1, "R5 negative clamp");

        // R8: mid-stream reset clears the history
        push(16'sd12345, 0, "R3 before reset");
        do_reset();
        push(16'sd100, 0, "R8 history cleared by reset");

        // R3: random stream with random output stalls
        for (int i = 0; i < 80; i++) begin
            push(16'($urandom()), int'($urandom_range(0, 3)), "R3 random stream");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule